// File: doc/BRIEF.md
# Threshold-Signalling Byte FIFO for a Display Data Channel Controller

This block is the byte buffer between a register-mapped data port and the serial bus engine of a display data channel controller. The transfer direction is chosen by an input. In write direction software pushes bytes and the bus engine drains them. In read direction the engine fills the buffer and software drains it. Software learns when to service the buffer from a request flag. On reads that flag rises once the fill level exceeds a programmed receive threshold. On writes it rises once the level drops under a programmed transmit threshold.

A control word holds both thresholds and a flush bit that clears itself. An 8-bit status word collects the request flag, three access-error flags raised by the buffer itself and four event pulses from the bus engine. Every status bit is cleared by writing a one to it. Software typically programs the thresholds, clears the status, starts the engine, and then moves one burst per request. With the receive threshold at 15, each request covers a burst of 16 bytes.

Top module: `ddc_xfer_fifo`

## Requirements
- R1: After reset the fill level is 0, the FIFO reports empty, and the status word and control word both read zero.
- R2: Accepted bytes leave in the order they entered. The fill level counts accepted pushes minus accepted pops and never exceeds DEPTH. `head_data` shows the oldest byte.
- R3: In write direction (`dir_wr`=1), a software push while the level equals DEPTH drops the byte and sets status bit 5 (overflow) on the next clock.
- R4: In read direction, a software pop while the FIFO is empty sets status bit 6 (underflow) on the next clock. `head_data` reads zero whenever the FIFO is empty.
- R5: A software access against the direction sets status bit 7 (illegal operation) and leaves the FIFO unchanged. The two such accesses are a pop in write direction and a push in read direction.
- R6: In read direction, status bit 4 (request) is set on the clock after a cycle in which the level is greater than the receive threshold, control bits 7:4.
- R7: In write direction, status bit 4 is set on the clock after a cycle in which the level is less than the transmit threshold, control bits 3:0.
- R8: Writing 1s through `sts_clr_mask` with `sts_clr_we` clears those status bits. A bit whose set condition holds in the same cycle stays set, so a cleared request comes back while its threshold condition still holds.
- R9: Writing control bit 31 as 1 makes bit 31 read 1 for exactly one cycle. At the end of that cycle the FIFO is emptied and bit 31 returns to 0. Data-port and engine accesses in that cycle are discarded and raise no error flag.
- R10: An engine event pulse `eng_evt[i]` sets status bit i. Bit 3 is arbitration error, bit 2 is ack error, bit 1 is bus error and bit 0 is transfer complete.
- R11: The engine side is ignored, with no flag, in three cases: an engine push when full, an engine pop when empty, and any engine access against the direction.
- R12: With the receive threshold at 15, the request rises only after the engine has stored 16 bytes, and software then drains all 16 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_wr | input | 1 | 1 = write direction (software fills), 0 = read direction (engine fills) |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control data: bit 31 flush, 7:4 receive threshold, 3:0 transmit threshold |
| ctrl_rdata | output | 32 | Control word read-back |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 8 | Write-one-to-clear mask for the status word |
| sts_q | output | 8 | Status word |
| sw_push | input | 1 | Software byte push |
| sw_wdata | input | 8 | Software push byte |
| sw_pop | input | 1 | Software byte pop |
| head_data | output | 8 | Oldest stored byte, zero when empty |
| eng_push | input | 1 | Engine byte push (read direction) |
| eng_wdata | input | 8 | Engine push byte |
| eng_pop | input | 1 | Engine byte pop (write direction) |
| eng_evt | input | 4 | Engine event pulses for status bits 3:0 |
| fifo_level | output | $clog2(DEPTH+1) | Current fill level |
| fifo_full | output | 1 | Level equals DEPTH |
| fifo_empty | output | 1 | Level is zero |

## Verification
The bench builds the block with its defaults: a depth of 16 and 4-bit thresholds. This lets a threshold of 15 call for exactly one full buffer, so the request-at-full corner, overflow on the seventeenth push and a 16-byte ordered drain are all reachable in a few dozen cycles. A power-of-two depth selects the natural pointer-wrap variant. The random phase changes direction, thresholds and flushes, and drives wrap-around repeatedly.

// File: rtl/ddc_fifo_pkg.sv
package ddc_fifo_pkg;

  localparam int CTRL_W      = 32;
  localparam int CTRL_FLUSH  = 31;
  localparam int STS_W       = 8;
  localparam int EVT_W       = 4;

  // status bit positions (decoded by software)
  localparam int STS_DONE    = 0;
  localparam int STS_BUS     = 1;
  localparam int STS_ACK     = 2;
  localparam int STS_ARB     = 3;
  localparam int STS_REQ     = 4;
  localparam int STS_OVF     = 5;
  localparam int STS_UNF     = 6;
  localparam int STS_ILL     = 7;

  typedef struct packed {
    logic ill;
    logic unf;
    logic ovf;
  } fifo_err_t;

endpackage

// File: rtl/ddc_fifo_ctrl.sv
module ddc_fifo_ctrl
  import ddc_fifo_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [THR_W-1:0]  rx_thr,
  output logic [THR_W-1:0]  tx_thr,
  output logic              flush_q,
  output logic [CTRL_W-1:0] ctrl_rdata
);

  logic [THR_W-1:0] rx_d, tx_d;
  logic             flush_d;
  logic             thr_en;
  logic             unused_bits;

  assign unused_bits = ^ctrl_wdata[CTRL_FLUSH-1:2*THR_W];

  always_comb begin
    thr_en  = ctrl_we;
    rx_d    = ctrl_wdata[2*THR_W-1:THR_W];
    tx_d    = ctrl_wdata[THR_W-1:0];
    // flush lasts one cycle unless rewritten
    flush_d = ctrl_we & ctrl_wdata[CTRL_FLUSH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr <= '0;
      tx_thr <= '0;
    end else if (thr_en) begin
      rx_thr <= rx_d;
      tx_thr <= tx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  always_comb begin
    ctrl_rdata                       = '0;
    ctrl_rdata[CTRL_FLUSH]           = flush_q;
    ctrl_rdata[2*THR_W-1:THR_W]      = rx_thr;
    ctrl_rdata[THR_W-1:0]            = tx_thr;
  end

endmodule

// File: rtl/ddc_fifo_arb.sv
module ddc_fifo_arb
  import ddc_fifo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dir_wr,
  input  logic             flushing,
  input  logic             full,
  input  logic             empty,
  input  logic             sw_push,
  input  logic             sw_pop,
  input  logic [WIDTH-1:0] sw_wdata,
  input  logic             eng_push,
  input  logic             eng_pop,
  input  logic [WIDTH-1:0] eng_wdata,
  output logic             do_push,
  output logic             do_pop,
  output logic [WIDTH-1:0] push_data,
  output fifo_err_t        err
);

  always_comb begin
    do_push   = 1'b0;
    do_pop    = 1'b0;
    push_data = sw_wdata;
    err       = '0;
    if (!flushing) begin
      if (dir_wr) begin
        // software fills, engine drains
        if (sw_push) begin
          if (full) err.ovf = 1'b1;
          else      do_push = 1'b1;
        end
        if (sw_pop)             err.ill = 1'b1;
        if (eng_pop && !empty)  do_pop  = 1'b1;
      end else begin
        // engine fills, software drains
        push_data = eng_wdata;
        if (sw_push)            err.ill = 1'b1;
        if (sw_pop) begin
          if (empty) err.unf = 1'b1;
          else       do_pop  = 1'b1;
        end
        if (eng_push && !full)  do_push = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddc_fifo_store.sv
module ddc_fifo_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_data,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] wr_inc, rd_inc;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  generate
    if (POW2) begin : g_pow2
      assign wr_inc = wr_ptr_q + 1'b1;
      assign rd_inc = rd_ptr_q + 1'b1;
    end else begin : g_wrap
      assign wr_inc = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_inc = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = wr_inc;
      if (pop)  rd_ptr_d = rd_inc;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
    ptr_en = flush | push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem_q[wr_ptr_q] <= push_data;
  end

  assign head  = mem_q[rd_ptr_q];
  assign level = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/ddc_fifo_status.sv
module ddc_fifo_status
  import ddc_fifo_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic             dir_wr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [THR_W-1:0] tx_thr,
  input  fifo_err_t        err,
  input  logic [EVT_W-1:0] eng_evt,
  input  logic             clr_we,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] sts_q
);

  logic             req_cond;
  logic [STS_W-1:0] set_vec, clr_vec, sts_d;
  logic             sts_en;

  always_comb begin
    if (dir_wr) req_cond = (32'(level) < 32'(tx_thr));
    else        req_cond = (32'(level) > 32'(rx_thr));

    set_vec                  = '0;
    set_vec[STS_ARB:STS_DONE] = eng_evt;
    set_vec[STS_REQ]         = req_cond;
    set_vec[STS_OVF]         = err.ovf;
    set_vec[STS_UNF]         = err.unf;
    set_vec[STS_ILL]         = err.ill;

    clr_vec = clr_we ? clr_mask : '0;
    // a set in the same cycle wins over the clear
    sts_d   = (sts_q & ~clr_vec) | set_vec;
    sts_en  = clr_we | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

endmodule

// File: rtl/ddc_xfer_fifo.sv
module ddc_xfer_fifo
  import ddc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int THR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dir_wr,
  input  logic                       ctrl_we,
  input  logic [31:0]                ctrl_wdata,
  output logic [31:0]                ctrl_rdata,
  input  logic                       sts_clr_we,
  input  logic [7:0]                 sts_clr_mask,
  output logic [7:0]                 sts_q,
  input  logic                       sw_push,
  input  logic [WIDTH-1:0]           sw_wdata,
  input  logic                       sw_pop,
  output logic [WIDTH-1:0]           head_data,
  input  logic                       eng_push,
  input  logic [WIDTH-1:0]           eng_wdata,
  input  logic                       eng_pop,
  input  logic [3:0]                 eng_evt,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  output logic                       fifo_full,
  output logic                       fifo_empty
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [THR_W-1:0] rx_thr, tx_thr;
  logic             flush_q;
  logic             do_push, do_pop;
  logic [WIDTH-1:0] push_data, head;
  fifo_err_t        err;

  ddc_fifo_ctrl #(.THR_W(THR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .rx_thr     (rx_thr),
    .tx_thr     (tx_thr),
    .flush_q    (flush_q),
    .ctrl_rdata (ctrl_rdata)
  );

  ddc_fifo_arb #(.WIDTH(WIDTH)) u_arb (
    .dir_wr    (dir_wr),
    .flushing  (flush_q),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .sw_push   (sw_push),
    .sw_pop    (sw_pop),
    .sw_wdata  (sw_wdata),
    .eng_push  (eng_push),
    .eng_pop   (eng_pop),
    .eng_wdata (eng_wdata),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .push_data (push_data),
    .err       (err)
  );

  ddc_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_q),
    .push      (do_push),
    .push_data (push_data),
    .pop       (do_pop),
    .head      (head),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  ddc_fifo_status #(.CNT_W(CNT_W), .THR_W(THR_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (fifo_level),
    .dir_wr   (dir_wr),
    .rx_thr   (rx_thr),
    .tx_thr   (tx_thr),
    .err      (err),
    .eng_evt  (eng_evt),
    .clr_we   (sts_clr_we),
    .clr_mask (sts_clr_mask),
    .sts_q    (sts_q)
  );

  assign head_data = fifo_empty ? '0 : head;

endmodule

// File: rtl/ddc_xfer_fifo_chk.sv
module ddc_xfer_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       dir_wr,
  input logic                       ctrl_we,
  input logic [31:0]                ctrl_wdata,
  input logic [31:0]                ctrl_rdata,
  input logic [7:0]                 sts_q,
  input logic                       sw_push,
  input logic                       sw_pop,
  input logic                       eng_push,
  input logic                       eng_pop,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic                       fifo_empty
);

  logic unused_wdata;
  assign unused_wdata = ^ctrl_wdata[30:0];

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_level) <= DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_push && dir_wr && 32'(fifo_level) == DEPTH && !ctrl_rdata[31]) |=> sts_q[5]);

  assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pop && !dir_wr && fifo_empty && !ctrl_rdata[31]) |=> sts_q[6]);

  assert_illegal_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((sw_push && !dir_wr) || (sw_pop && dir_wr)) && !ctrl_rdata[31]) |=> sts_q[7]);

  assert_read_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_wr && 32'(fifo_level) > 32'(ctrl_rdata[2*THR_W-1:THR_W])) |=> sts_q[4]);

  assert_write_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr && 32'(fifo_level) < 32'(ctrl_rdata[THR_W-1:0])) |=> sts_q[4]);

  assert_flush_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[31] && !(ctrl_we && ctrl_wdata[31])) |=> (!ctrl_rdata[31] && fifo_empty));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_push && !sw_pop && !eng_push && !eng_pop && !ctrl_rdata[31]) |=> $stable(fifo_level));

endmodule

bind ddc_xfer_fifo ddc_xfer_fifo_chk #(.DEPTH(DEPTH), .THR_W(THR_W)) u_chk (.*);

// File: tb/ddc_xfer_fifo_bench.sv
`timescale 1ns/1ps
module ddc_xfer_fifo_bench;

  localparam int DEPTH = 16;
  localparam int THR_W = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk;
  logic             rst_n;
  logic             dir_wr;
  logic             ctrl_we;
  logic [31:0]      ctrl_wdata;
  logic [31:0]      ctrl_rdata;
  logic             sts_clr_we;
  logic [7:0]       sts_clr_mask;
  logic [7:0]       sts_q;
  logic             sw_push;
  logic [7:0]       sw_wdata;
  logic             sw_pop;
  logic [7:0]       head_data;
  logic             eng_push;
  logic [7:0]       eng_wdata;
  logic             eng_pop;
  logic [3:0]       eng_evt;
  logic [LVL_W-1:0] fifo_level;
  logic             fifo_full;
  logic             fifo_empty;

  ddc_xfer_fifo #(.DEPTH(DEPTH), .WIDTH(8), .THR_W(THR_W)) u_ddc_xfer_fifo (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  logic [7:0] mq[$];
  logic [7:0] m_sts;
  logic [3:0] m_rx, m_tx;
  logic       m_flush;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic compare();
    logic [7:0] exp_head;
    exp_head = (mq.size() != 0) ? mq[0] : 8'h00;
    chk(fifo_level == LVL_W'(mq.size()), "R2 level", 32'(fifo_level), 32'(mq.size()));
    chk(fifo_empty == (mq.size() == 0), "R2 empty", 32'(fifo_empty), 32'(mq.size() == 0));
    chk(fifo_full == (mq.size() == DEPTH), "R2 full", 32'(fifo_full), 32'(mq.size() == DEPTH));
    chk(sts_q == m_sts, "R8 status", 32'(sts_q), 32'(m_sts));
    chk(ctrl_rdata == {m_flush, 23'b0, m_rx, m_tx}, "R9 control", ctrl_rdata, {m_flush, 23'b0, m_rx, m_tx});
    chk(head_data == exp_head, "R4 head", 32'(head_data), 32'(exp_head));
  endtask

  task automatic model_update();
    int         n;
    logic [7:0] set;
    logic [7:0] clr;
    logic [7:0] pd;
    bit         dp, dpop;
    n    = mq.size();
    set  = 8'h00;
    dp   = 1'b0;
    dpop = 1'b0;
    pd   = 8'h00;
    set[3:0] = eng_evt;
    set[4]   = dir_wr ? (n < int'(m_tx)) : (n > int'(m_rx));
    if (!m_flush) begin
      if (sw_push) begin
        if (!dir_wr)        set[7] = 1'b1;
        else if (n >= DEPTH) set[5] = 1'b1;
        else begin dp = 1'b1; pd = sw_wdata; end
      end
      if (sw_pop) begin
        if (dir_wr)      set[7] = 1'b1;
        else if (n == 0) set[6] = 1'b1;
        else             dpop = 1'b1;
      end
      if (eng_push && !dir_wr && n < DEPTH) begin dp = 1'b1; pd = eng_wdata; end
      if (eng_pop && dir_wr && n > 0) dpop = 1'b1;
      if (dpop) void'(mq.pop_front());
      if (dp)   mq.push_back(pd);
    end else begin
      mq.delete();
    end
    clr   = sts_clr_we ? sts_clr_mask : 8'h00;
    m_sts = (m_sts & ~clr) | set;
    if (ctrl_we) begin
      m_rx    = ctrl_wdata[7:4];
      m_tx    = ctrl_wdata[3:0];
      m_flush = ctrl_wdata[31];
    end else begin
      m_flush = 1'b0;
    end
  endtask

  task automatic idle();
    ctrl_we = 1'b0; ctrl_wdata = '0;
    sts_clr_we = 1'b0; sts_clr_mask = '0;
    sw_push = 1'b0; sw_pop = 1'b0; sw_wdata = '0;
    eng_push = 1'b0; eng_pop = 1'b0; eng_wdata = '0; eng_evt = '0;
  endtask

  // inputs are set at a falling edge; one call covers one rising edge
  task automatic tick();
    model_update();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; tick();
  endtask

  task automatic clr_sts(input logic [7:0] m);
    sts_clr_we = 1'b1; sts_clr_mask = m; tick();
  endtask

  initial begin
    #(200_000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dir_wr = 1'b1;
    idle();
    mq.delete();
    m_sts = '0; m_rx = '0; m_tx = '0; m_flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fifo_level == 0 && fifo_empty, "R1 level", 32'(fifo_level), 0);
    chk(sts_q == 8'h00, "R1 status", 32'(sts_q), 0);
    chk(ctrl_rdata == 32'h0, "R1 control", ctrl_rdata, 0);
    compare();

    // write direction, tx threshold 4, rx threshold 15
    wr_ctrl(32'h0000_00F4);
    tick();
    chk(sts_q[4] == 1'b1, "R7 request when below tx threshold", 32'(sts_q[4]), 1);

    for (int i = 0; i < 5; i++) begin sw_push = 1'b1; sw_wdata = 8'hA0 + 8'(i); tick(); end
    clr_sts(8'h10);
    chk(sts_q[4] == 1'b0, "R8 clear takes effect", 32'(sts_q[4]), 0);
    chk(head_data == 8'hA0, "R2 oldest byte at head", 32'(head_data), 32'hA0);

    eng_pop = 1'b1; tick();
    chk(head_data == 8'hA1, "R2 order after engine pop", 32'(head_data), 32'hA1);
    eng_pop = 1'b1; tick();
    tick();
    chk(sts_q[4] == 1'b1, "R7 request after drain to 3", 32'(sts_q[4]), 1);
    clr_sts(8'h10);
    chk(sts_q[4] == 1'b1, "R8 set wins while condition holds", 32'(sts_q[4]), 1);

    for (int i = 0; i < 13; i++) begin sw_push = 1'b1; sw_wdata = 8'h50 + 8'(i); tick(); end
    chk(fifo_full == 1'b1, "R2 full at depth", 32'(fifo_full), 1);
    sw_push = 1'b1; sw_wdata = 8'hEE; tick();
    chk(sts_q[5] == 1'b1, "R3 overflow flag", 32'(sts_q[5]), 1);
    chk(32'(fifo_level) == DEPTH, "R3 byte dropped", 32'(fifo_level), DEPTH);

    sw_pop = 1'b1; tick();
    chk(sts_q[7] == 1'b1, "R5 pop in write direction", 32'(sts_q[7]), 1);
    chk(32'(fifo_level) == DEPTH && head_data == 8'hA2, "R5 fifo unchanged", 32'(head_data), 32'hA2);

    eng_evt = 4'hF; tick();
    chk(sts_q[3:0] == 4'hF, "R10 engine events", 32'(sts_q[3:0]), 32'hF);
    clr_sts(8'hFF);
    chk(sts_q == 8'h00, "R8 clear all", 32'(sts_q), 0);
    eng_evt = 4'h4; tick();
    chk(sts_q[3:0] == 4'h4, "R10 ack error only", 32'(sts_q[3:0]), 32'h4);

    wr_ctrl(32'h8000_00F4);
    chk(ctrl_rdata[31] == 1'b1, "R9 flush visible", 32'(ctrl_rdata[31]), 1);
    sw_push = 1'b1; sw_wdata = 8'h77; tick();
    chk(fifo_level == 0 && ctrl_rdata[31] == 1'b0, "R9 flushed and self-cleared", 32'(fifo_level), 0);
    chk(sts_q[5] == 1'b0, "R9 access in flush cycle no flag", 32'(sts_q[5]), 0);

    // read direction
    dir_wr = 1'b0;
    clr_sts(8'hFF);
    eng_pop = 1'b1; tick();
    chk(sts_q == 8'h00 && fifo_level == 0, "R11 engine pop ignored in read", 32'(sts_q), 0);
    sw_pop = 1'b1; tick();
    chk(sts_q[6] == 1'b1, "R4 underflow flag", 32'(sts_q[6]), 1);
    chk(head_data == 8'h00, "R4 empty head reads zero", 32'(head_data), 0);

    for (int i = 0; i < DEPTH; i++) begin eng_push = 1'b1; eng_wdata = 8'h30 + 8'(i); tick(); end
    chk(sts_q[4] == 1'b0, "R6 no request at 16 before sample", 32'(sts_q[4]), 0);
    tick();
    chk(sts_q[4] == 1'b1, "R12 request after 16 bytes", 32'(sts_q[4]), 1);
    eng_push = 1'b1; eng_wdata = 8'hFF; tick();
    chk(sts_q[5] == 1'b0 && 32'(fifo_level) == DEPTH, "R11 engine push full ignored", 32'(sts_q[5]), 0);
    sw_push = 1'b1; sw_wdata = 8'h11; tick();
    chk(sts_q[7] == 1'b1 && 32'(fifo_level) == DEPTH, "R5 push in read direction", 32'(sts_q[7]), 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk(head_data == 8'h30 + 8'(i), "R12 burst order", 32'(head_data), 32'(8'h30 + 8'(i)));
      sw_pop = 1'b1; tick();
    end
    chk(fifo_empty == 1'b1, "R12 drained", 32'(fifo_empty), 1);

    wr_ctrl(32'h0000_0034);
    clr_sts(8'hFF);
    for (int i = 0; i < 4; i++) begin eng_push = 1'b1; eng_wdata = 8'hC0 + 8'(i); tick(); end
    tick();
    chk(sts_q[4] == 1'b1, "R6 request above rx threshold 3", 32'(sts_q[4]), 1);
    sw_pop = 1'b1; tick();
    clr_sts(8'h10);
    chk(sts_q[4] == 1'b0, "R6 request clears at threshold", 32'(sts_q[4]), 0);

    // random phase compared against the model on every clock
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 31) == 0) dir_wr = ~dir_wr;
      sw_push  = ($urandom_range(0, 3) == 0);
      sw_pop   = ($urandom_range(0, 3) == 0);
      eng_push = ($urandom_range(0, 2) == 0);
      eng_pop  = ($urandom_range(0, 2) == 0);
      sw_wdata = 8'($urandom);
      eng_wdata = 8'($urandom);
      eng_evt  = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      if ($urandom_range(0, 5) == 0) begin
        sts_clr_we = 1'b1; sts_clr_mask = 8'($urandom);
      end
      if ($urandom_range(0, 40) == 0) begin
        ctrl_we = 1'b1;
        ctrl_wdata = {($urandom_range(0, 3) == 0), 23'b0, 8'($urandom)};
      end
      tick();
    end

    summary();
    $finish;
  end

endmodule